// File: doc/BRIEF.md
# NRZI Bit Receiver with Unstuffing

This block sits behind a timing-recovery stage on a low/full-speed serial bus receiver. Once the recovery stage has found the start of a packet, it raises `sop_i` for one cycle. It then hands over one line symbol per bit time, sampled mid-bit, with a strobe. The receiver turns those symbols into NRZI-decoded data bits and drops the inserted stuff bits. It also follows the end-of-packet sequence. Its results are single-cycle pulses: a data bit with its value, a discarded stuff bit, a completed end of packet, a stuff violation, or a malformed end of packet.

After an end of packet or any error, the receiver goes idle. It ignores strobes until the next `sop_i`. SE0, SE1 and the J that closes an end of packet never yield data bits. Every result appears on the registered outputs one clock after the strobe that caused it.

Top module: `nrzi_rx`

## Requirements
- R1: While `rst_ni` is low and after its release, every output is low and the receiver is idle.
- R2: Symbol encoding on `sym_i`: 2'b00 SE0, 2'b01 J, 2'b10 K, 2'b11 SE1. In reception, a J or K equal to the previous symbol decodes as 1 and a change decodes as 0. The reference symbol is J right after `sop_i`. The result is given on `bit_vld_o`/`bit_o` one cycle after the strobe.
- R3: A bit that follows six consecutive decoded 1s and decodes as 0 is a stuff bit. It gives a `stuff_o` pulse instead of a data bit and clears the count of ones.
- R4: A bit that follows six consecutive decoded 1s and decodes as 1 gives a `stuff_err_o` pulse, and the receiver goes idle.
- R5: A decoded 0 data bit clears the count of consecutive 1s, so a new run of six is needed before a stuff bit is expected.
- R6: SE0 during bit reception produces no output and starts end-of-packet detection.
- R7: During end-of-packet detection, further SE0 symbols produce no output. A J then gives an `eop_o` pulse with no data bit, and the receiver goes idle.
- R8: K or SE1 during end-of-packet detection gives an `eop_err_o` pulse, and the receiver goes idle.
- R9: SE1 during bit reception gives an `eop_err_o` pulse, and the receiver goes idle.
- R10: In idle, strobes produce no output. `sop_i` restarts reception from any state, with the reference at J and the ones count at zero.
- R11: A strobe in the same cycle as `sop_i` is ignored.
- R12: At most one of the five result pulses is high in any cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| sop_i | input | 1 | Start-of-packet pulse from timing recovery |
| sym_vld_i | input | 1 | Mid-bit symbol strobe |
| sym_i | input | 2 | Line symbol (encoding in R2) |
| bit_vld_o | output | 1 | Decoded data bit valid |
| bit_o | output | 1 | Decoded data bit value |
| stuff_o | output | 1 | Stuff bit discarded |
| eop_o | output | 1 | End of packet completed |
| stuff_err_o | output | 1 | Bit-stuff violation |
| eop_err_o | output | 1 | Malformed end of packet or SE1 |

## Verification
Every result is registered once, so each output is due exactly one clock after the strobe or `sop_i` that caused it. The bench drives inputs on the falling edge. It then samples all six outputs a quarter period after the next rising edge and compares them with a reference model stepped once per driven cycle. Cycles with no strobe are checked too: they must show all outputs low. This catches pulses that last too long or arrive late. Random packets are built by stuffing, NRZI-encoding and terminating random bit strings, with random gaps between strobes. Directed sequences cover stuff errors, bad end-of-packet symbols, SE1, restarts and strobes that coincide with `sop_i`.

// File: rtl/nrzi_rx_pkg.sv
package nrzi_rx_pkg;
  typedef enum logic [1:0] {
    SYM_SE0 = 2'b00,
    SYM_J   = 2'b01,
    SYM_K   = 2'b10,
    SYM_SE1 = 2'b11
  } line_sym_e;

  typedef enum logic [1:0] {
    ST_IDLE = 2'b00,
    ST_RECV = 2'b01,
    ST_EOP  = 2'b10
  } rx_state_e;

  typedef enum logic [2:0] {
    EV_NONE,
    EV_BIT,
    EV_STUFF,
    EV_EOP,
    EV_STUFF_ERR,
    EV_EOP_ERR
  } rx_event_e;
endpackage

// File: rtl/nrzi_bit_decode.sv
module nrzi_bit_decode
  import nrzi_rx_pkg::*;
(
  input  logic [1:0] sym_i,
  input  logic [1:0] prev_i,
  output logic       is_data_o,
  output logic       bit_o
);
  always_comb begin
    is_data_o = (sym_i == SYM_J) || (sym_i == SYM_K);
    bit_o     = (sym_i == prev_i);
  end
endmodule

// File: rtl/nrzi_ones_tracker.sv
module nrzi_ones_tracker #(
  parameter int MAX_ONES = 6,
  localparam int CNT_W   = $clog2(MAX_ONES + 1)
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic clr_i,
  input  logic upd_i,
  input  logic bit_i,
  output logic at_limit_o
);
  logic [CNT_W-1:0] cnt_q;

  assign at_limit_o = (cnt_q == CNT_W'(MAX_ONES));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                cnt_q <= '0;
    else if (clr_i)             cnt_q <= '0;
    else if (upd_i) begin
      if (at_limit_o || !bit_i) cnt_q <= '0;
      else                      cnt_q <= cnt_q + 1'b1;
    end
  end

  p_cnt_bound_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_q <= CNT_W'(MAX_ONES));
  p_clr_zero_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    clr_i |=> (cnt_q == '0));
  p_zero_clears_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (upd_i && !clr_i && !bit_i) |=> (cnt_q == '0));
endmodule

// File: rtl/nrzi_eop_check.sv
module nrzi_eop_check
  import nrzi_rx_pkg::*;
(
  input  logic [1:0] sym_i,
  output logic       hold_o,
  output logic       done_o,
  output logic       err_o
);
  always_comb begin
    hold_o = (sym_i == SYM_SE0);
    done_o = (sym_i == SYM_J);
    err_o  = !hold_o && !done_o;
  end
endmodule

// File: rtl/nrzi_rx.sv
module nrzi_rx
  import nrzi_rx_pkg::*;
#(
  parameter int MAX_ONES = 6
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       sop_i,
  input  logic       sym_vld_i,
  input  logic [1:0] sym_i,
  output logic       bit_vld_o,
  output logic       bit_o,
  output logic       stuff_o,
  output logic       eop_o,
  output logic       stuff_err_o,
  output logic       eop_err_o
);
  rx_state_e state_q, state_d;
  logic [1:0] prev_q, prev_d;
  rx_event_e  ev;
  logic       is_data, dec_bit, at_limit, trk_upd;
  logic       eop_hold, eop_done, eop_err;

  nrzi_bit_decode u_dec (
    .sym_i    (sym_i),
    .prev_i   (prev_q),
    .is_data_o(is_data),
    .bit_o    (dec_bit)
  );

  assign trk_upd = sym_vld_i && (state_q == ST_RECV) && is_data;

  nrzi_ones_tracker #(.MAX_ONES(MAX_ONES)) u_trk (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .clr_i     (sop_i),
    .upd_i     (trk_upd),
    .bit_i     (dec_bit),
    .at_limit_o(at_limit)
  );

  nrzi_eop_check u_eop (
    .sym_i (sym_i),
    .hold_o(eop_hold),
    .done_o(eop_done),
    .err_o (eop_err)
  );

  always_comb begin
    state_d = state_q;
    prev_d  = prev_q;
    ev      = EV_NONE;
    if (sop_i) begin
      state_d = ST_RECV;
      prev_d  = SYM_J;
    end else if (sym_vld_i) begin
      unique case (state_q)
        ST_RECV: begin
          if (is_data) begin
            prev_d = sym_i;
            if (at_limit) begin
              if (dec_bit) begin
                ev      = EV_STUFF_ERR;
                state_d = ST_IDLE;
              end else begin
                ev = EV_STUFF;
              end
            end else begin
              ev = EV_BIT;
            end
          end else if (sym_i == SYM_SE0) begin
            state_d = ST_EOP;
          end else begin
            ev      = EV_EOP_ERR;
            state_d = ST_IDLE;
          end
        end
        ST_EOP: begin
          if (eop_done) begin
            ev      = EV_EOP;
            state_d = ST_IDLE;
          end else if (eop_err) begin
            ev      = EV_EOP_ERR;
            state_d = ST_IDLE;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q     <= ST_IDLE;
      prev_q      <= SYM_J;
      bit_vld_o   <= 1'b0;
      bit_o       <= 1'b0;
      stuff_o     <= 1'b0;
      eop_o       <= 1'b0;
      stuff_err_o <= 1'b0;
      eop_err_o   <= 1'b0;
    end else begin
      state_q     <= state_d;
      prev_q      <= prev_d;
      bit_vld_o   <= (ev == EV_BIT);
      bit_o       <= (ev == EV_BIT) && dec_bit;
      stuff_o     <= (ev == EV_STUFF);
      eop_o       <= (ev == EV_EOP);
      stuff_err_o <= (ev == EV_STUFF_ERR);
      eop_err_o   <= (ev == EV_EOP_ERR);
    end
  end

  p_one_event_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0({bit_vld_o, stuff_o, eop_o, stuff_err_o, eop_err_o}));
  p_quiet_after_end_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (eop_o || stuff_err_o || eop_err_o) |=> !(bit_vld_o || stuff_o));
  p_eop_after_se0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    eop_o |-> ($past(state_q) == ST_EOP));
  p_stuff_at_limit_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (stuff_o || stuff_err_o) |-> $past(at_limit));
  p_sop_no_result_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sop_i |=> !(bit_vld_o || stuff_o || eop_o || stuff_err_o || eop_err_o));
endmodule

// File: tb/sim_nrzi_rx.sv
module sim_nrzi_rx;
  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic sop_i = 1'b0, sym_vld_i = 1'b0;
  logic [1:0] sym_i = 2'b01;
  logic bit_vld_o, bit_o, stuff_o, eop_o, stuff_err_o, eop_err_o;

  localparam logic [1:0] SE0 = 2'b00, J = 2'b01, K = 2'b10, SE1 = 2'b11;

  int n_chk = 0, n_bad = 0;
  int m_state = 0;          // 0 idle, 1 receive, 2 eop
  logic [1:0] m_prev = J;
  int m_ones = 0;

  always #10 clk = ~clk;

  nrzi_rx u0 (
    .clk_i(clk), .rst_ni(rst_ni), .sop_i(sop_i), .sym_vld_i(sym_vld_i), .sym_i(sym_i),
    .bit_vld_o(bit_vld_o), .bit_o(bit_o), .stuff_o(stuff_o), .eop_o(eop_o),
    .stuff_err_o(stuff_err_o), .eop_err_o(eop_err_o)
  );

  task automatic check(input string req, input logic [5:0] exp);
    logic [5:0] act;
    act = {bit_vld_o, bit_o, stuff_o, eop_o, stuff_err_o, eop_err_o};
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: outputs {vld,bit,stuff,eop,serr,eerr} act=%b exp=%b", req, act, exp);
    end
  endtask

  task automatic step(input logic s, input logic v, input logic [1:0] y);
    logic [5:0] exp;
    string req;
    logic b;
    @(negedge clk);
    sop_i = s; sym_vld_i = v; sym_i = y;
    exp = '0; req = "R2";
    if (s) begin
      req = v ? "R11" : "R10";
      m_state = 1; m_prev = J; m_ones = 0;
    end else if (v) begin
      case (m_state)
        1: begin
          if (y == J || y == K) begin
            b = (y == m_prev);
            m_prev = y;
            if (m_ones == 6) begin
              if (!b) begin exp[3] = 1'b1; m_ones = 0; req = "R3"; end
              else begin exp[1] = 1'b1; m_state = 0; req = "R4"; end
            end else begin
              exp[5] = 1'b1; exp[4] = b;
              m_ones = b ? m_ones + 1 : 0;
              req = b ? "R2" : "R5";
            end
          end else if (y == SE0) begin
            m_state = 2; req = "R6";
          end else begin
            exp[0] = 1'b1; m_state = 0; req = "R9";
          end
        end
        2: begin
          if (y == SE0) req = "R7";
          else if (y == J) begin exp[2] = 1'b1; m_state = 0; req = "R7"; end
          else begin exp[0] = 1'b1; m_state = 0; req = "R8"; end
        end
        default: req = "R10";
      endcase
    end
    @(posedge clk);
    #5;
    check(req, exp);
  endtask

  task automatic strobe(input logic [1:0] y);
    int gap;
    gap = $urandom_range(0, 3);
    for (int g = 0; g < gap; g++) step(1'b0, 1'b0, y);
    step(1'b0, 1'b1, y);
  endtask

  // random packet: stuffed, NRZI encoded, terminated
  task automatic rand_pkt(input int nbits, input int bias);
    logic [1:0] cur;
    int ones;
    logic b;
    cur = J; ones = 0;
    step(1'b1, 1'b0, J);
    for (int i = 0; i < nbits; i++) begin
      if (ones == 6) begin
        b = 1'b0; ones = 0;
      end else begin
        b = ($urandom_range(0, 99) < bias);
        ones = b ? ones + 1 : 0;
      end
      if (!b) cur = (cur == J) ? K : J;
      strobe(cur);
    end
    for (int i = 0; i < int'($urandom_range(1, 3)); i++) strobe(SE0);
    strobe(J);
    strobe(J);
  endtask

  initial begin
    #(20ns * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: act=hung exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    void'($urandom(32'd1234));
    #35;
    check("R1", 6'b0);
    rst_ni = 1'b1;
    step(1'b0, 1'b0, J);
    // R1/R10: idle after reset ignores strobes
    step(1'b0, 1'b1, K);
    step(1'b0, 1'b1, SE1);
    // R2: K,K,J,J -> 0,1,0,1 ; then EOP R7
    step(1'b1, 1'b0, J);
    step(1'b0, 1'b1, K); step(1'b0, 1'b1, K);
    step(1'b0, 1'b1, J); step(1'b0, 1'b1, J);
    step(1'b0, 1'b1, SE0); step(1'b0, 1'b1, J);
    step(1'b0, 1'b1, J);
    // R3 then R4: six ones, stuff 0, six ones, then 1
    step(1'b1, 1'b0, J);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, J);
    step(1'b0, 1'b1, K);
    for (int i = 0; i < 6; i++) step(1'b0, 1'b1, K);
    step(1'b0, 1'b1, K);
    step(1'b0, 1'b1, J);
    // R5: five ones, a zero, five ones -> no stuff expected
    step(1'b1, 1'b0, J);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, J);
    step(1'b0, 1'b1, K);
    for (int i = 0; i < 5; i++) step(1'b0, 1'b1, K);
    step(1'b0, 1'b1, J);
    // R8: SE0 then K, and SE0 then SE1
    step(1'b0, 1'b1, SE0); step(1'b0, 1'b1, K); step(1'b0, 1'b1, K);
    step(1'b1, 1'b0, J);
    step(1'b0, 1'b1, SE0); step(1'b0, 1'b1, SE1);
    // R9: SE1 while receiving
    step(1'b1, 1'b0, J);
    step(1'b0, 1'b1, K); step(1'b0, 1'b1, SE1); step(1'b0, 1'b1, K);
    // R10: sop during eop detection restarts with J reference
    step(1'b1, 1'b0, J);
    step(1'b0, 1'b1, SE0);
    step(1'b1, 1'b0, K);
    step(1'b0, 1'b1, J);
    // R11: strobe coincident with sop is ignored
    step(1'b1, 1'b1, K);
    step(1'b0, 1'b1, J);
    step(1'b0, 1'b1, SE0); step(1'b0, 1'b1, SE0); step(1'b0, 1'b1, J);
    // random packets and random raw symbol streams
    for (int p = 0; p < 150; p++) begin
      rand_pkt($urandom_range(1, 40), (p % 3 == 0) ? 95 : 60);
      if (p % 5 == 0) begin
        step(1'b1, 1'b0, J);
        for (int i = 0; i < 20; i++)
          step(($urandom_range(0, 30) == 0), ($urandom_range(0, 3) != 0), 2'($urandom_range(0, 3)));
      end
    end
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule